// File: doc/BRIEF.md
# Second-Chance Direct-Mapped Read Cache

This block is a read-only cache that is direct-mapped but gives each access a second chance. Each request is looked up first at its home slot, chosen by the index bits of the address. If the home slot does not hold the line, the block probes one partner slot. The partner slot's index is the home index with its top bit flipped. A match in the partner slot is a slow hit. After a slow hit, the block swaps the two slots so that the line just used sits in its home slot and hits quickly next time.

When neither slot holds the line, the block asks memory for the whole line and waits for the fill. It writes the new line into the home slot. The line that was in the home slot moves to the partner slot, and the line that was in the partner slot is lost. The processor side is a valid/ready request port with a registered response carrying one word. The memory side issues one line request at a time and takes back a full line in a single beat.

The default geometry is a 2 KB cache with 16-byte lines and 32-bit byte addresses. This gives 128 slots.

Top module: `pac_cache`

## Requirements
- R1: After reset every slot is empty, `reqReady` is 1, and `respValid`, `respPseudo`, `respFill` and `memReqValid` are 0. With the default geometry, the first access to any address therefore goes to memory.
- R2: A request accepted when the home slot holds its line gives `respValid`=1 with `respPseudo`=0 and `respFill`=0 in the cycle after acceptance. `reqReady` stays 1, so hits can follow back to back.
- R3: Address fields: bits [3:0] are the byte offset, and bits [3:2] select the 32-bit word of the line. Bits [10:4] are the home index. The stored tag is bits [31:10], which includes the top index bit. A line sitting in the partner slot therefore never matches an address whose bits [31:11] are equal but whose bit 10 differs.
- R4: On a home miss, the partner slot (index bit 6, i.e. address bit 10, inverted) is checked. A match gives `respValid`=1 with `respPseudo`=1 two cycles after acceptance, returning the selected word.
- R5: After a slow hit, the home and partner slots have exchanged contents. The same address then hits in one cycle, and the displaced line becomes a slow hit.
- R6: `reqReady` is 0 from the cycle after a home miss is accepted until the access completes. This includes the single swap cycle, which coincides with the slow-hit response. Requests offered while `reqReady` is 0 are not accepted and produce no response.
- R7: When both slots miss, `memReqValid` rises one cycle after the partner probe. It carries the line-aligned address (low 4 bits zero) and is held until `memFillValid`. In the cycle after the fill beat, the block gives `respValid`=1 with `respFill`=1 and the selected word of the filled line, and `reqReady` returns to 1.
- R8: A fill puts the new line in the home slot and moves the previous home line, valid or not, to the partner slot. The previous partner line is discarded.
- R9: `memFillValid` asserted while no line request is pending has no effect on the contents or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request offered |
| reqAddr | input | 32 | Byte address of the read |
| reqReady | output | 1 | Request accepted on this edge when high with `reqValid` |
| respValid | output | 1 | Response word is valid this cycle |
| respData | output | 32 | Word read |
| respPseudo | output | 1 | Response came from the partner slot |
| respFill | output | 1 | Response came from a memory fill |
| memReqValid | output | 1 | Line request pending |
| memReqAddr | output | 32 | Line-aligned address of the request |
| memFillValid | input | 1 | Fill line present this cycle |
| memFillData | input | 128 | Fill line, word 0 in the low bits |

## Verification
The bench opens with a cold miss. It follows with back-to-back hits on different words of that line, which separate word selection from hit timing. Next it accesses a second tag at the same home index, forcing a fill that moves the first line to its partner slot. Alternating the two tags then checks the slow hit and the swap. An address that differs from a resident line only in index bit 6 checks that the tag includes the top index bit and that the previous partner line is discarded. A stray fill beat and requests offered while not ready show that neither leaves a trace. A pseudo-random walk over eight lines competing for two slots, with varying fill latency, mixes all three outcomes.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALT,
    ST_SWAP,
    ST_FILL
  } pacState_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic hitPrim;    // accepted request hits its home slot
    logic missLatch;  // accepted request missed home slot, capture it
    logic hitAlt;     // partner probe matched
    logic swapLines;  // exchange home and partner slots
    logic fillDone;   // fill beat consumed
  } pacStrobes_t;

  // lookup results from the datapath back to control
  typedef struct packed {
    logic primHit;
    logic altHit;
  } pacStatus_t;

endpackage

// File: rtl/pac_control.sv
module pac_control
  import pac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memFillValid,
  input  pacStatus_t  status,
  output pacStrobes_t strobes,
  output logic        reqReady,
  output logic        memReqValid
);

  pacState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobes     = '0;
    nextState   = state;
    reqReady    = (state == ST_IDLE);
    memReqValid = (state == ST_FILL);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (status.primHit) begin
            strobes.hitPrim = 1'b1;
          end else begin
            strobes.missLatch = 1'b1;
            nextState         = ST_ALT;
          end
        end
      end
      ST_ALT: begin
        if (status.altHit) begin
          strobes.hitAlt = 1'b1;
          nextState      = ST_SWAP;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_SWAP: begin
        strobes.swapLines = 1'b1;
        nextState         = ST_IDLE;
      end
      ST_FILL: begin
        if (memFillValid) begin
          strobes.fillDone = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_NOT_READY_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !status.primHit |=> !reqReady); // R6

  AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memFillValid |=> memReqValid); // R7

  AST_NO_MEMREQ_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid); // R7

endmodule

// File: rtl/pac_datapath.sv
module pac_datapath
  import pac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 16,
  parameter int WORD_W      = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  pacStrobes_t               strobes,
  output pacStatus_t                status,
  output logic [ADDR_W-1:0]         memReqAddr,
  input  logic [LINE_BYTES*8-1:0]   memFillData,
  output logic                      respValid,
  output logic [WORD_W-1:0]         respData,
  output logic                      respPseudo,
  output logic                      respFill
);

  localparam int LINE_W    = LINE_BYTES * 8;
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int BYTE_OFF  = $clog2(WORD_W / 8);
  localparam int WSEL_W    = OFF_W - BYTE_OFF;
  localparam int TAG_LSB   = OFF_W + IDX_W - 1;   // tag keeps the top index bit
  localparam int TAG_W     = ADDR_W - TAG_LSB;
  localparam logic [IDX_W-1:0] MSB_FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [LINE_W-1:0] line_t;

  logic [NUM_LINES-1:0] validVec;
  tag_t                 tagArr  [NUM_LINES];
  line_t                dataArr [NUM_LINES];

  logic [ADDR_W-1:0] qAddr;

  idx_t              primIdx, qPrimIdx, qAltIdx;
  tag_t              reqTag, qTag;
  logic [WSEL_W-1:0] reqWsel, qWsel;

  assign primIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag   = reqAddr[ADDR_W-1:TAG_LSB];
  assign reqWsel  = reqAddr[BYTE_OFF +: WSEL_W];
  assign qPrimIdx = qAddr[OFF_W +: IDX_W];
  assign qAltIdx  = qPrimIdx ^ MSB_FLIP;
  assign qTag     = qAddr[ADDR_W-1:TAG_LSB];
  assign qWsel    = qAddr[BYTE_OFF +: WSEL_W];

  logic unusedBits;
  assign unusedBits = ^{reqAddr[BYTE_OFF-1:0], qAddr[BYTE_OFF-1:0]};

  // lookups: home slot from the live request, partner slot from the captured one
  assign status.primHit = validVec[primIdx] && (tagArr[primIdx] == reqTag);
  assign status.altHit  = validVec[qAltIdx] && (tagArr[qAltIdx] == qTag);

  assign memReqAddr = {qAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN)                  qAddr <= '0;
    else if (strobes.missLatch) qAddr <= reqAddr;
  end

  // per-slot valid bits, cleared on reset
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[i] <= 1'b0;
      end else if (strobes.fillDone) begin
        if (qPrimIdx == idx_t'(i))     validVec[i] <= 1'b1;
        else if (qAltIdx == idx_t'(i)) validVec[i] <= validVec[qPrimIdx];
      end else if (strobes.swapLines) begin
        if (qPrimIdx == idx_t'(i))     validVec[i] <= validVec[qAltIdx];
        else if (qAltIdx == idx_t'(i)) validVec[i] <= validVec[qPrimIdx];
      end
    end
  end

  // tag and line storage: no reset, guarded by valid bits
  always_ff @(posedge clk) begin
    if (strobes.fillDone) begin
      tagArr[qPrimIdx]  <= qTag;
      dataArr[qPrimIdx] <= memFillData;
      tagArr[qAltIdx]   <= tagArr[qPrimIdx];
      dataArr[qAltIdx]  <= dataArr[qPrimIdx];
    end else if (strobes.swapLines) begin
      tagArr[qPrimIdx]  <= tagArr[qAltIdx];
      dataArr[qPrimIdx] <= dataArr[qAltIdx];
      tagArr[qAltIdx]   <= tagArr[qPrimIdx];
      dataArr[qAltIdx]  <= dataArr[qPrimIdx];
    end
  end

  line_t primLine, altLine;
  assign primLine = dataArr[primIdx];
  assign altLine  = dataArr[qAltIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respPseudo <= 1'b0;
      respFill   <= 1'b0;
      respData   <= '0;
    end else begin
      respValid  <= strobes.hitPrim | strobes.hitAlt | strobes.fillDone;
      respPseudo <= strobes.hitAlt;
      respFill   <= strobes.fillDone;
      if (strobes.hitPrim)       respData <= primLine[reqWsel*WORD_W +: WORD_W];
      else if (strobes.hitAlt)   respData <= altLine[qWsel*WORD_W +: WORD_W];
      else if (strobes.fillDone) respData <= memFillData[qWsel*WORD_W +: WORD_W];
    end
  end

  AST_PSEUDO_MOVES_LINE: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respPseudo |=> validVec[qPrimIdx] && (tagArr[qPrimIdx] == qTag)); // R5

  AST_FILL_LANDS_HOME: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respFill |-> validVec[qPrimIdx] && (tagArr[qPrimIdx] == qTag)); // R8

  AST_RESP_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({respPseudo, respFill}) && (respValid || !(respPseudo || respFill))); // R4

endmodule

// File: rtl/pac_cache.sv
module pac_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 16,
  parameter int WORD_W      = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    reqReady,
  output logic                    respValid,
  output logic [WORD_W-1:0]       respData,
  output logic                    respPseudo,
  output logic                    respFill,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memFillValid,
  input  logic [LINE_BYTES*8-1:0] memFillData
);

  pacStrobes_t strobes;
  pacStatus_t  status;

  pac_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memFillValid (memFillValid),
    .status       (status),
    .strobes      (strobes),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid)
  );

  pac_datapath #(
    .ADDR_W      (ADDR_W),
    .CACHE_BYTES (CACHE_BYTES),
    .LINE_BYTES  (LINE_BYTES),
    .WORD_W      (WORD_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .strobes     (strobes),
    .status      (status),
    .memReqAddr  (memReqAddr),
    .memFillData (memFillData),
    .respValid   (respValid),
    .respData    (respData),
    .respPseudo  (respPseudo),
    .respFill    (respFill)
  );

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && status.primHit |=> respValid && !respPseudo && !respFill); // R2

  AST_PSEUDO_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !status.primHit ##1 status.altHit |=> respValid && respPseudo); // R4

endmodule

// File: tb/pac_cache_bench.sv
module pac_cache_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic         reqReady;
  logic         respValid;
  logic [31:0]  respData;
  logic         respPseudo;
  logic         respFill;
  logic         memReqValid;
  logic [31:0]  memReqAddr;
  logic         memFillValid = 1'b0;
  logic [127:0] memFillData = '0;

  always #2.5 clk = ~clk;

  pac_cache u_pac_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .respValid(respValid), .respData(respData),
    .respPseudo(respPseudo), .respFill(respFill), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memFillValid(memFillValid), .memFillData(memFillData)
  );

  int nCmp = 0;
  int nBad = 0;

  // behavioural reference: 128 slots
  bit           mValid [128];
  logic [21:0]  mTag   [128];
  logic [127:0] mLine  [128];

  function automatic logic [127:0] memLine(input logic [27:0] la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++)
      l[w*32 +: 32] = (32'(la) * 32'h9E37_79B1) ^ (32'(w + 1) * 32'h0101_0101);
    return l;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a, input int lat, input bit noisy);
    int pi, ai, kind;
    logic [21:0]  t;
    logic [127:0] ln;
    pi = int'(a[10:4]);
    ai = pi ^ 64;
    t  = a[31:10];
    if (mValid[pi] && mTag[pi] == t)      kind = 0;
    else if (mValid[ai] && mTag[ai] == t) kind = 1;
    else                                  kind = 2;
    check("R6", "ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqAddr  = a;
    tick();
    reqValid = 1'b0;
    if (kind == 0) begin
      ln = mLine[pi];
      check("R2", "hit respValid", 32'(respValid), 32'd1);
      check("R2", "hit respPseudo", 32'(respPseudo), 32'd0);
      check("R2", "hit respFill", 32'(respFill), 32'd0);
      check("R2", "hit ready", 32'(reqReady), 32'd1);
      check("R3", "hit word", respData, ln[a[3:2]*32 +: 32]);
    end else begin
      check("R4", "probe respValid", 32'(respValid), 32'd0);
      check("R6", "probe ready", 32'(reqReady), 32'd0);
      check("R7", "probe memReqValid", 32'(memReqValid), 32'd0);
      if (noisy) begin
        reqValid = 1'b1;
        reqAddr  = a ^ 32'h0000_3000;
      end
      tick();
      if (kind == 1) begin
        ln = mLine[ai];
        check("R4", "pseudo respValid", 32'(respValid), 32'd1);
        check("R4", "pseudo respPseudo", 32'(respPseudo), 32'd1);
        check("R4", "pseudo respFill", 32'(respFill), 32'd0);
        check("R4", "pseudo word", respData, ln[a[3:2]*32 +: 32]);
        check("R6", "swap ready", 32'(reqReady), 32'd0);
        mValid[ai] = mValid[pi]; mValid[pi] = 1'b1;
        mTag[ai]   = mTag[pi];   mTag[pi]   = t;
        mLine[ai]  = mLine[pi];  mLine[pi]  = ln;
        tick();
        reqValid = 1'b0;
        check("R6", "ready after swap", 32'(reqReady), 32'd1);
        check("R6", "no extra response", 32'(respValid), 32'd0);
      end else begin
        check("R7", "memReqValid", 32'(memReqValid), 32'd1);
        check("R7", "memReqAddr", memReqAddr, {a[31:4], 4'b0});
        check("R6", "fill ready", 32'(reqReady), 32'd0);
        check("R7", "wait respValid", 32'(respValid), 32'd0);
        for (int k = 0; k < lat; k++) begin
          tick();
          check("R7", "memReqValid held", 32'(memReqValid), 32'd1);
        end
        reqValid     = 1'b0;
        ln           = memLine(a[31:4]);
        memFillValid = 1'b1;
        memFillData  = ln;
        tick();
        memFillValid = 1'b0;
        memFillData  = ~ln;
        check("R7", "fill respValid", 32'(respValid), 32'd1);
        check("R7", "fill respFill", 32'(respFill), 32'd1);
        check("R7", "fill respPseudo", 32'(respPseudo), 32'd0);
        check("R7", "fill word", respData, ln[a[3:2]*32 +: 32]);
        check("R7", "ready after fill", 32'(reqReady), 32'd1);
        check("R7", "memReqValid dropped", 32'(memReqValid), 32'd0);
        // R8: old home line moves to partner, old partner dropped
        mValid[ai] = mValid[pi]; mValid[pi] = 1'b1;
        mTag[ai]   = mTag[pi];   mTag[pi]   = t;
        mLine[ai]  = mLine[pi];  mLine[pi]  = ln;
      end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  localparam logic [31:0] A_ADDR = 32'h0000_0120;  // home 0x12
  localparam logic [31:0] B_ADDR = 32'h0000_0520;  // home 0x52, bit 10 set
  localparam logic [31:0] C_ADDR = 32'h0001_0120;  // home 0x12, other tag

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 128; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset ready", 32'(reqReady), 32'd1);
    check("R1", "reset respValid", 32'(respValid), 32'd0);
    check("R1", "reset respPseudo", 32'(respPseudo), 32'd0);
    check("R1", "reset respFill", 32'(respFill), 32'd0);
    check("R1", "reset memReqValid", 32'(memReqValid), 32'd0);
    rstN = 1'b1;
    tick();
    access(A_ADDR, 2, 1'b0);            // R1 cold miss
    access(A_ADDR + 8, 0, 1'b0);        // R2/R3 back-to-back hits
    access(A_ADDR + 4, 0, 1'b0);
    access(A_ADDR + 12, 0, 1'b0);
    access(C_ADDR, 0, 1'b0);            // R8 A moves to partner
    access(A_ADDR + 4, 0, 1'b0);        // R4 slow hit, R5 swap
    access(A_ADDR, 0, 1'b0);            // R5 now fast
    access(C_ADDR + 8, 0, 1'b1);        // R5 displaced line slow, R6 noisy
    access(C_ADDR, 0, 1'b0);
    access(B_ADDR, 3, 1'b1);            // R3 bit-10 tag, R8 drop C
    access(A_ADDR, 0, 1'b0);
    access(C_ADDR + 4, 1, 1'b0);        // R8 C was discarded
    // R9 stray fill beat
    memFillValid = 1'b1;
    memFillData  = '1;
    tick();
    memFillValid = 1'b0;
    check("R9", "stray fill respValid", 32'(respValid), 32'd0);
    check("R9", "stray fill memReqValid", 32'(memReqValid), 32'd0);
    check("R9", "stray fill ready", 32'(reqReady), 32'd1);
    access(C_ADDR + 4, 0, 1'b0);
    access(A_ADDR + 8, 0, 1'b0);
    lfsr = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      logic [31:0] ra;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = (32'(lfsr[1:0]) << 16) | (32'(lfsr[2]) << 10) | 32'h120 | (32'(lfsr[4:3]) << 2);
      access(ra, int'(lfsr[6:5]) % 3, lfsr[7]);
    end
    summary();
    $finish;
  end

endmodule